// File: doc/BRIEF.md
# Bidirectional Column Strobe Sequencer

This block generates the sampling strobes for a row of display column outputs. A start pulse arrives on the input pin at one end of the row. The block turns it into a strobe that moves along the columns. When the strobe leaves the far end, the block raises a cascade pulse on the pin at that end, so the next device in a chain can start its own sweep. The direction input chooses which end is the input and which end is the output.

The strobe moves in one of two ways. A 2-bit pixel-array mode input selects the way.

- **Simultaneous stepping:** the strobe covers a group of three neighbouring columns, and only clock phase 1 moves it.
- **Successive stepping:** the strobe covers a single column, and it advances on the rising edge of each of the three clock phases in turn.

The three phase inputs are level signals sampled on the block clock. Their rising edges are detected inside the block.

Top module: `sample_strobe_shifter`

## Requirements
- R1: After a synchronous active-low reset, all strobes and both cascade outputs are 0, and the start detector is cleared. This holds even if a sweep was running.
- R2: In simultaneous stepping with `dir_fwd`=1, a phase-1 rising edge while `lo_start_in` is high sets strobes 0, 1 and 2 and clears all others.
- R3: In simultaneous stepping, each later phase-1 rising edge moves the 3-column group up by three columns (down by three in reverse). Rising edges on phase 2 and phase 3 leave the strobes unchanged. With no phase edge, the strobes hold.
- R4: In successive stepping, the start edge sets only strobe 0 (forward). Each later rising edge of any phase moves the single strobe one column.
- R5: With `dir_fwd`=0, `hi_start_in` is the start input and `lo_start_in` is ignored. The sweep begins at the top column(s) (column N-1, or N-3 to N-1) and moves toward column 0.
- R6: Start capture is edge based. A start pulse held high across several phase-1 edges loads the chain only on the first of those edges. The later edges step the strobe normally.
- R7: The step that moves the strobe past the last column raises the far-end cascade output: `hi_carry_out` when forward, `lo_carry_out` when reverse. The next step clears it. The near-end output stays 0.
- R8: `array_mode` 2'b11 (vertical stripe) selects simultaneous stepping. The values 2'b00, 2'b01 and 2'b10 (the delta and mosaic arrays) select successive stepping.
- R9: No more than three strobes are ever active at the same time.
- R10: A start pulse is captured only on a phase-1 rising edge. A start pulse that is high during a phase-2 or phase-3 edge does not load the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; phase inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ph1 | input | 1 | Clock phase 1 (level); it also qualifies the start pulse |
| ph2 | input | 1 | Clock phase 2 (level); used only in successive stepping |
| ph3 | input | 1 | Clock phase 3 (level); used only in successive stepping |
| dir_fwd | input | 1 | 1: sweep from column 0 upward; 0: sweep from column N-1 downward |
| array_mode | input | 2 | Pixel-array mode; 2'b11 selects simultaneous stepping |
| lo_start_in | input | 1 | Start pulse at the low end, used when dir_fwd=1 |
| hi_start_in | input | 1 | Start pulse at the high end, used when dir_fwd=0 |
| lo_carry_out | output | 1 | Cascade pulse out of the low end (reverse sweep) |
| hi_carry_out | output | 1 | Cascade pulse out of the high end (forward sweep) |
| strobe | output | N_COLS | Column sampling strobes |

## Verification
Every strobe and cascade result is due at the first rising edge of `clk` at which a phase input is seen high after being low. That is one register stage after the phase input changes. The bench changes inputs on the falling edge, samples on the following falling edge, and then holds all phases low for one full cycle so that the next pulse is again a fresh edge. A table walks both directions in both stepping schemes, with a small column count. The table includes the ignored-phase, ignored-pin, stretched-start and cascade corners. Directed steps then cover reset in the middle of a sweep.

// File: rtl/ssr_pkg.sv
// Package: shared types for the column strobe sequencer.
// Assumes a 2-bit pixel-array mode code; only the stripe code selects
// simultaneous (group) stepping.
package ssr_pkg;

    typedef enum logic [1:0] {
        ARR_DELTA_ONE  = 2'b00,
        ARR_MOSAIC     = 2'b01,
        ARR_DELTA_TWO  = 2'b10,
        ARR_STRIPE     = 2'b11
    } array_mode_e;

    // Returns 1 when the array mode calls for group-wide simultaneous stepping.
    function automatic logic is_simultaneous(input logic [1:0] mode);
        return (mode == ARR_STRIPE);
    endfunction

endpackage

// File: rtl/phase_edge_detect.sv
// Module: phase_edge_detect
// Detects rising edges on NPH level-sampled clock phase inputs.
// Assumes the phase inputs are synchronous to clk; a rise is flagged in the
// cycle in which an input is first seen high after being low.
module phase_edge_detect #(
    parameter int NPH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NPH-1:0] ph,
    output logic [NPH-1:0] rise
);

    logic [NPH-1:0] ph_q;

    // Remember each phase level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph;
    end

    for (genvar k = 0; k < NPH; k++) begin : g_rise
        // Flag a low-to-high transition on phase k.
        assign rise[k] = ph[k] & ~ph_q[k];
    end

endmodule

// File: rtl/start_capture.sv
// Module: start_capture
// Picks the start input on the entry side of the sweep and converts a held
// start pulse into a single load request on the first phase-1 rising edge.
// Assumes the start input is synchronous to clk.
module start_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic rise1,
    input  logic dir_fwd,
    input  logic lo_start_in,
    input  logic hi_start_in,
    output logic load
);

    logic start_sel;
    logic taken_q;

    // Entry pin follows the direction; the other pin is ignored.
    assign start_sel = dir_fwd ? lo_start_in : hi_start_in;

    // Load only once per high period of the start pulse.
    assign load = rise1 & start_sel & ~taken_q;

    // Track whether the current start pulse has already been consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)          taken_q <= 1'b0;
        else if (!start_sel) taken_q <= 1'b0;
        else if (rise1)      taken_q <= 1'b1;
    end

    AST_LOAD_ON_PH1: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> rise1); // R10

endmodule

// File: rtl/strobe_chain.sv
// Module: strobe_chain
// N-stage strobe register that is seeded by a load and shifted on each step.
// The stride is GROUP columns in simultaneous stepping and one column
// otherwise, and the shift goes up or down with dir_fwd. The bit that leaves
// the far end is kept as the carry until the next step.
// Assumes N is a multiple of GROUP and N > GROUP.
module strobe_chain #(
    parameter int N     = 240,
    parameter int GROUP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic         dir_fwd,
    input  logic         simul,
    output logic [N-1:0] chain,
    output logic         carry
);

    localparam int LAST = N - 1;

    logic [N-1:0] chain_q;
    logic [N-1:0] nxt;
    logic         carry_q;

    for (genvar i = 0; i < N; i++) begin : g_stage
        logic up1, up3, dn1, dn3, seed;
        if (i >= 1)         begin : g_u1 assign up1 = chain_q[i-1];     end
        else                begin : g_u0 assign up1 = 1'b0;             end
        if (i >= GROUP)     begin : g_ug assign up3 = chain_q[i-GROUP]; end
        else                begin : g_uz assign up3 = 1'b0;             end
        if (i <= LAST - 1)  begin : g_d1 assign dn1 = chain_q[i+1];     end
        else                begin : g_d0 assign dn1 = 1'b0;             end
        if (i <= LAST - GROUP) begin : g_dg assign dn3 = chain_q[i+GROUP]; end
        else                begin : g_dz assign dn3 = 1'b0;             end
        // Seed pattern for this stage when a start pulse is loaded.
        assign seed = dir_fwd ? (simul ? (i < GROUP) : (i == 0))
                              : (simul ? (i > LAST - GROUP) : (i == LAST));
        // Next value: the seed on a load, otherwise the neighbour at the stride.
        assign nxt[i] = load ? seed
                             : (dir_fwd ? (simul ? up3 : up1)
                                        : (simul ? dn3 : dn1));
    end

    // Advance the chain and capture the bit leaving the far end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            carry_q <= 1'b0;
        end else if (step | load) begin
            chain_q <= nxt;
            carry_q <= dir_fwd ? chain_q[LAST] : chain_q[0];
        end
    end

    assign chain = chain_q;
    assign carry = carry_q;

    AST_STROBE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chain_q) <= GROUP); // R9

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step | load) |=> $stable(chain_q)); // R3

    AST_CARRY_FROM_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_q) |-> $past(chain_q[LAST] | chain_q[0])); // R7

endmodule

// File: rtl/sample_strobe_shifter.sv
// Module: sample_strobe_shifter (top)
// Column strobe sequencer. It decodes the stepping scheme from the array
// mode, detects the phase edges, qualifies the start pulse on the entry
// side, and drives the strobe chain and the cascade output at the far end.
// Assumes all inputs are synchronous to clk.
module sample_strobe_shifter
    import ssr_pkg::*;
#(
    parameter int N_COLS = 240,
    parameter int GROUP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ph1,
    input  logic              ph2,
    input  logic              ph3,
    input  logic              dir_fwd,
    input  logic [1:0]        array_mode,
    input  logic              lo_start_in,
    input  logic              hi_start_in,
    output logic              lo_carry_out,
    output logic              hi_carry_out,
    output logic [N_COLS-1:0] strobe
);

    localparam int NPH = 3;

    logic [NPH-1:0] rise;
    logic           simul;
    logic           step;
    logic           load;
    logic           carry;

    // Stepping scheme comes from the pixel-array mode.
    assign simul = is_simultaneous(array_mode);

    phase_edge_detect #(.NPH(NPH)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    ({ph3, ph2, ph1}),
        .rise  (rise)
    );

    // Phase 1 alone steps in simultaneous mode; any phase steps otherwise.
    assign step = simul ? rise[0] : (|rise);

    start_capture u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise1       (rise[0]),
        .dir_fwd     (dir_fwd),
        .lo_start_in (lo_start_in),
        .hi_start_in (hi_start_in),
        .load        (load)
    );

    strobe_chain #(.N(N_COLS), .GROUP(GROUP)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load    (load),
        .dir_fwd (dir_fwd),
        .simul   (simul),
        .chain   (strobe),
        .carry   (carry)
    );

    // The cascade pulse leaves through the pin at the far end of the sweep.
    assign hi_carry_out = carry & dir_fwd;
    assign lo_carry_out = carry & ~dir_fwd;

endmodule

// File: tb/tb_sample_strobe_shifter.sv
module tb_sample_strobe_shifter;

    localparam int N = 12;

    typedef struct packed {
        logic [1:0] mode;
        logic       dir;
        logic [1:0] ph;
        logic       slo;
        logic       shi;
        logic [4:0] col;
        logic [1:0] cnt;
        logic       clo;
        logic       chi;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [0:NV-1] = '{
        '{2'd3,1'b1,2'd1,1'b1,1'b0,5'd0 ,2'd3,1'b0,1'b0,4'd2 }, // R2 load group
        '{2'd3,1'b1,2'd1,1'b1,1'b0,5'd3 ,2'd3,1'b0,1'b0,4'd6 }, // R6 stretched start
        '{2'd3,1'b1,2'd2,1'b0,1'b0,5'd3 ,2'd3,1'b0,1'b0,4'd3 }, // R3 ph2 ignored
        '{2'd3,1'b1,2'd3,1'b0,1'b0,5'd3 ,2'd3,1'b0,1'b0,4'd3 }, // R3 ph3 ignored
        '{2'd3,1'b1,2'd1,1'b0,1'b0,5'd6 ,2'd3,1'b0,1'b0,4'd3 },
        '{2'd3,1'b1,2'd1,1'b0,1'b0,5'd9 ,2'd3,1'b0,1'b0,4'd3 },
        '{2'd3,1'b1,2'd1,1'b0,1'b0,5'd31,2'd0,1'b0,1'b1,4'd7 }, // R7 carry up
        '{2'd3,1'b1,2'd1,1'b0,1'b0,5'd31,2'd0,1'b0,1'b0,4'd7 }, // R7 carry clears
        '{2'd0,1'b1,2'd2,1'b1,1'b0,5'd31,2'd0,1'b0,1'b0,4'd10}, // R10 no load on ph2
        '{2'd0,1'b1,2'd1,1'b1,1'b0,5'd0 ,2'd1,1'b0,1'b0,4'd4 }, // R4
        '{2'd0,1'b1,2'd2,1'b0,1'b0,5'd1 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd3,1'b0,1'b0,5'd2 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd1,1'b0,1'b0,5'd3 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd2,1'b0,1'b0,5'd4 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd3,1'b0,1'b0,5'd5 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd1,1'b0,1'b0,5'd6 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd2,1'b0,1'b0,5'd7 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd3,1'b0,1'b0,5'd8 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd1,1'b0,1'b0,5'd9 ,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd2,1'b0,1'b0,5'd10,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd3,1'b0,1'b0,5'd11,2'd1,1'b0,1'b0,4'd4 },
        '{2'd0,1'b1,2'd1,1'b0,1'b0,5'd31,2'd0,1'b0,1'b1,4'd7 }, // R7
        '{2'd0,1'b1,2'd2,1'b0,1'b0,5'd31,2'd0,1'b0,1'b0,4'd7 },
        '{2'd3,1'b0,2'd1,1'b1,1'b0,5'd31,2'd0,1'b0,1'b0,4'd5 }, // R5 low pin ignored
        '{2'd3,1'b0,2'd1,1'b0,1'b1,5'd9 ,2'd3,1'b0,1'b0,4'd5 }, // R5 reverse group
        '{2'd3,1'b0,2'd1,1'b0,1'b0,5'd6 ,2'd3,1'b0,1'b0,4'd5 },
        '{2'd3,1'b0,2'd1,1'b0,1'b0,5'd3 ,2'd3,1'b0,1'b0,4'd5 },
        '{2'd3,1'b0,2'd1,1'b0,1'b0,5'd0 ,2'd3,1'b0,1'b0,4'd5 },
        '{2'd3,1'b0,2'd1,1'b0,1'b0,5'd31,2'd0,1'b1,1'b0,4'd7 }, // R7 low end
        '{2'd3,1'b0,2'd1,1'b0,1'b0,5'd31,2'd0,1'b0,1'b0,4'd7 },
        '{2'd1,1'b0,2'd1,1'b0,1'b1,5'd11,2'd1,1'b0,1'b0,4'd5 }, // R5 reverse single
        '{2'd1,1'b0,2'd2,1'b0,1'b0,5'd10,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd3,1'b0,1'b0,5'd9 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd1,1'b0,1'b0,5'd8 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd2,1'b0,1'b0,5'd7 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd3,1'b0,1'b0,5'd6 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd1,1'b0,1'b0,5'd5 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd2,1'b0,1'b0,5'd4 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd3,1'b0,1'b0,5'd3 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd1,1'b0,1'b0,5'd2 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd2,1'b0,1'b0,5'd1 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd3,1'b0,1'b0,5'd0 ,2'd1,1'b0,1'b0,4'd5 },
        '{2'd1,1'b0,2'd1,1'b0,1'b0,5'd31,2'd0,1'b1,1'b0,4'd7 }, // R7
        '{2'd2,1'b1,2'd1,1'b1,1'b0,5'd0 ,2'd1,1'b0,1'b0,4'd8 }, // R8 code 10
        '{2'd2,1'b1,2'd2,1'b0,1'b0,5'd1 ,2'd1,1'b0,1'b0,4'd8 }  // R8
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ph1, ph2, ph3, dir_fwd, lo_start_in, hi_start_in;
    logic [1:0]   array_mode;
    logic         lo_carry_out, hi_carry_out;
    logic [N-1:0] strobe;
    int           total = 0;
    int           bad = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    sample_strobe_shifter #(.N_COLS(N), .GROUP(3)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ph1          (ph1),
        .ph2          (ph2),
        .ph3          (ph3),
        .dir_fwd      (dir_fwd),
        .array_mode   (array_mode),
        .lo_start_in  (lo_start_in),
        .hi_start_in  (hi_start_in),
        .lo_carry_out (lo_carry_out),
        .hi_carry_out (hi_carry_out),
        .strobe       (strobe)
    );

    function automatic logic [N-1:0] mask(input int col, input int cnt);
        logic [N-1:0] m = '0;
        for (int c = 0; c < N; c++)
            if (cnt != 0 && c >= col && c < col + cnt) m[c] = 1'b1;
        return m;
    endfunction

    task automatic check(input string req, input logic [N-1:0] exp_s,
                         input logic exp_lo, input logic exp_hi);
        total++;
        if (strobe !== exp_s || lo_carry_out !== exp_lo || hi_carry_out !== exp_hi) begin
            bad++;
            $display("FAIL %s strobe=%b lo=%b hi=%b expected strobe=%b lo=%b hi=%b",
                     req, strobe, lo_carry_out, hi_carry_out, exp_s, exp_lo, exp_hi);
        end
    endtask

    // One phase pulse: raise at a falling edge, check one cycle later, drop.
    task automatic pulse(input logic [1:0] mode, input logic dir, input int ph,
                         input logic slo, input logic shi);
        @(negedge clk);
        array_mode = mode; dir_fwd = dir; lo_start_in = slo; hi_start_in = shi;
        ph1 = (ph == 1); ph2 = (ph == 2); ph3 = (ph == 3);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ph1 = 0; ph2 = 0; ph3 = 0; dir_fwd = 1'b1;
        array_mode = 2'b11; lo_start_in = 0; hi_start_in = 0;
        repeat (3) @(negedge clk);
        check("R1", '0, 1'b0, 1'b0);                 // R1 reset state
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            pulse(TBL[v].mode, TBL[v].dir, int'(TBL[v].ph), TBL[v].slo, TBL[v].shi);
            check($sformatf("R%0d row %0d", TBL[v].req, v),
                  mask(int'(TBL[v].col), int'(TBL[v].cnt)), TBL[v].clo, TBL[v].chi);
            ph1 = 0; ph2 = 0; ph3 = 0;
        end

        // R1: reset in the middle of a sweep clears strobes and carries.
        pulse(2'b00, 1'b1, 2, 1'b0, 1'b0);
        ph2 = 0;
        check("R4 mid sweep", mask(2, 1), 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-sweep reset", '0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1: the start detector is fresh after reset.
        pulse(2'b11, 1'b1, 1, 1'b1, 1'b0);
        ph1 = 0;
        check("R1 restart", mask(0, 3), 1'b0, 1'b0);
        // R3: with no phase edge at all, strobes hold.
        repeat (4) @(negedge clk);
        check("R3 hold", mask(0, 3), 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule